// File: doc/BRIEF.md
# Transmit Dominant-Time Guard

This block sits between a serial protocol controller and the low-side driver of a single-wire bus. The controller's transmit-data line asks for a dominant (near-ground) bus with a low level and a recessive bus with a high level. The block turns that request into a gated driver command. It also runs a watchdog on how long the bus has been held dominant. When transmit data stays low for too long, for example because a hardware or software failure has stuck it, the watchdog turns the driver off. The bus then floats back to recessive and other nodes can use it again.

The watchdog counts ticks of an external timebase. With the default threshold this gives about 9 ms at a 1 µs tick, which puts the slowest usable bit rate near 2.4 kbps. The count starts when transmit data goes low and restarts when it goes high again. A trip holds the driver off until transmit data is released. The driver is also held off while the transmitter-enable input from the mode controller is low and while the thermal fault flag is high. The transmit-data input is synchronised before use. Its synchroniser resets to the dominant level, so an undriven input that sits low after reset is timed out and cannot hold the bus.

Top module: `dst_guard`

## Requirements
- R1: With tx_en_i high, thermal_fault_i low and no timeout, drv_on_o goes high exactly SYNC_STAGES clock edges after txd_i is driven low (0 = dominant request).
- R2: drv_on_o is low whenever the synchronised transmit data is high (1 = recessive request).
- R3: drv_on_o is low whenever tx_en_i is low.
- R4: drv_on_o is low while thermal_fault_i is high. If transmit data is still low and no timeout has occurred, driving resumes in the cycle the fault clears.
- R5: After TIMEOUT_TICKS ticks sampled during one continuous low period of the synchronised transmit data, dom_timeout_o is high and drv_on_o is low from the clock edge that samples the last tick.
- R6: After TIMEOUT_TICKS-1 such ticks the driver is still on and dom_timeout_o is still low.
- R7: Once tripped, the timeout stays latched while transmit data stays low, however many more ticks arrive. The count saturates and never wraps.
- R8: A high level on the synchronised transmit data clears dom_timeout_o and the count. The next low period must then collect a full TIMEOUT_TICKS ticks before it trips again.
- R9: A short high pulse on txd_i during a low period restarts the count from zero.
- R10: The synchroniser and the count reset to the dominant state. If txd_i is low when reset is released, counting starts at once and the first TIMEOUT_TICKS ticks trip the timeout.
- R11: Ticks are counted whatever the levels of tx_en_i and thermal_fault_i. A trip that happens while the driver is gated off still holds it off when enable returns.
- R12: Ticks that arrive while transmit data is high are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_i | input | 1 | Transmit data from protocol controller, 0 = dominant, 1 = recessive |
| tx_en_i | input | 1 | Transmitter enable from mode controller |
| thermal_fault_i | input | 1 | Thermal shutdown flag, high disables driver |
| tick_i | input | 1 | One-cycle timebase pulse, one per watchdog unit |
| drv_on_o | output | 1 | Low-side driver command, high pulls bus dominant |
| dom_timeout_o | output | 1 | Sticky dominant-timeout flag, cleared by transmit data going high |

## Verification
The bench builds the block with TIMEOUT_TICKS = 16 and SYNC_STAGES = 2. The short threshold puts the trip boundary, the last tick before it and saturation well past it within a few hundred cycles. The bench drives every tick itself, so it knows the exact edge at which the trip must happen. Two synchroniser stages make the input latency large enough to check it to the exact edge, and still short enough to run a one-cycle restart pulse through the pipeline.

// File: rtl/dst_pkg.sv
package dst_pkg;

  // Bus level requested on the transmit-data line
  typedef enum logic {
    LVL_DOM = 1'b0,
    LVL_REC = 1'b1
  } bus_lvl_e;

  // True when the level requests a driven (dominant) bus
  function automatic logic wants_dominant(input logic lvl);
    return (lvl == LVL_DOM);
  endfunction

endpackage

// File: rtl/dst_sync.sv
module dst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  import dst_pkg::*;

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] stg_q;
      // Resets to dominant so a floating input is timed from reset
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q <= {STAGES{LVL_DOM}};
        end else if (STAGES == 1) begin
          stg_q[0] <= d_i;
        end else begin
          stg_q <= {stg_q[STAGES-2:0], d_i};
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dst_timer.sv
module dst_timer #(
  parameter int LIMIT = 9000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic tick_i,
  output logic tripped_o
);
  import dst_pkg::*;

  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             trip_q;

  // Count while dominant; any recessive sample restarts. Stops once tripped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (!wants_dominant(lvl_i)) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (tick_i && !trip_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        trip_q <= 1'b1;
      end
    end
  end

  assign tripped_o = trip_q;

endmodule

// File: rtl/dst_gate.sv
module dst_gate (
  input  logic lvl_i,
  input  logic en_i,
  input  logic fault_i,
  input  logic tripped_i,
  output logic drv_o
);
  import dst_pkg::*;

  always_comb begin
    drv_o = en_i & ~fault_i & ~tripped_i & wants_dominant(lvl_i);
  end

endmodule

// File: rtl/dst_guard.sv
module dst_guard #(
  parameter int TIMEOUT_TICKS = 9000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic tx_en_i,
  input  logic thermal_fault_i,
  input  logic tick_i,
  output logic drv_on_o,
  output logic dom_timeout_o
);

  logic txd_s;
  logic trip;

  dst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (txd_i),
    .q_o   (txd_s)
  );

  dst_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (txd_s),
    .tick_i    (tick_i),
    .tripped_o (trip)
  );

  dst_gate u_gate (
    .lvl_i     (txd_s),
    .en_i      (tx_en_i),
    .fault_i   (thermal_fault_i),
    .tripped_i (trip),
    .drv_o     (drv_on_o)
  );

  assign dom_timeout_o = trip;

endmodule

// File: rtl/dst_guard_chk.sv
module dst_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic txd_s,
  input logic tx_en_i,
  input logic thermal_fault_i,
  input logic drv_on_o,
  input logic dom_timeout_o
);

  AST_RECESSIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    txd_s |-> !drv_on_o); // R2

  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |-> !drv_on_o); // R3

  AST_FAULT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_fault_i |-> !drv_on_o); // R4

  AST_TRIP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    dom_timeout_o |-> !drv_on_o); // R5

  AST_TRIP_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_timeout_o && !txd_s) |=> dom_timeout_o); // R7

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    txd_s |=> !dom_timeout_o); // R8

endmodule

bind dst_guard dst_guard_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .txd_s           (txd_s),
  .tx_en_i         (tx_en_i),
  .thermal_fault_i (thermal_fault_i),
  .drv_on_o        (drv_on_o),
  .dom_timeout_o   (dom_timeout_o)
);

// File: tb/dst_guard_bench.sv
`timescale 1ns/1ps
module dst_guard_bench;
  localparam int TO   = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1;
  logic tx_en = 1'b1;
  logic fault = 1'b0;
  logic tick = 1'b0;
  logic drv_on;
  logic dom_to;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dst_guard #(.TIMEOUT_TICKS(TO), .SYNC_STAGES(SYNC)) u_dst_guard (
    .clk             (clk),
    .rst_n           (rst_n),
    .txd_i           (txd),
    .tx_en_i         (tx_en),
    .thermal_fault_i (fault),
    .tick_i          (tick),
    .drv_on_o        (drv_on),
    .dom_timeout_o   (dom_to)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst_n = 1'b0; txd = lvl; tx_en = 1'b1; fault = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_txd(input logic v);
    @(negedge clk); txd = v;
    repeat (SYNC + 1) @(negedge clk);
  endtask

  task automatic t_reset_state;
    do_reset(1'b1);
    repeat (SYNC + 1) @(negedge clk);
    check("R2 reset idle drv", drv_on, 1'b0);
    check("R2 reset idle flag", dom_to, 1'b0);
  endtask

  task automatic t_latency;
    @(negedge clk); txd = 1'b0;
    repeat (SYNC - 1) @(negedge clk);
    check("R1 not yet driving", drv_on, 1'b0);
    @(negedge clk);
    check("R1 driving after sync", drv_on, 1'b1);
    set_txd(1'b1);
    check("R2 recessive stops drive", drv_on, 1'b0);
  endtask

  task automatic t_enable_fault;
    set_txd(1'b0);
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk);
    check("R3 enable low", drv_on, 1'b0);
    tx_en = 1'b1; fault = 1'b1;
    @(negedge clk);
    check("R4 fault blocks", drv_on, 1'b0);
    fault = 1'b0;
    #1;
    check("R4 resumes after fault", drv_on, 1'b1);
    set_txd(1'b1);
  endtask

  task automatic t_boundary;
    set_txd(1'b0);
    ticks(12);                     // R12: recessive ticks below do not add
    set_txd(1'b1);
    ticks(TO);
    set_txd(1'b0);
    ticks(TO - 1);
    check("R6 one short drv", drv_on, 1'b1);
    check("R6 one short flag", dom_to, 1'b0);
    check("R12 high ticks ignored", dom_to, 1'b0);
    ticks(1);
    check("R5 trip drv", drv_on, 1'b0);
    check("R5 trip flag", dom_to, 1'b1);
    ticks(3 * TO);
    check("R7 latched after many ticks", dom_to, 1'b1);
    check("R7 drv held off", drv_on, 1'b0);
    set_txd(1'b1);
    check("R8 release clears flag", dom_to, 1'b0);
    set_txd(1'b0);
    check("R8 drive allowed again", drv_on, 1'b1);
    ticks(TO - 1);
    check("R8 full count needed", dom_to, 1'b0);
    ticks(1);
    check("R8 retrip", dom_to, 1'b1);
    set_txd(1'b1);
  endtask

  task automatic t_restart_pulse;
    set_txd(1'b0);
    ticks(TO - 2);
    @(negedge clk); txd = 1'b1;
    @(negedge clk); txd = 1'b0;
    repeat (SYNC + 1) @(negedge clk);
    ticks(TO - 1);
    check("R9 restarted count", dom_to, 1'b0);
    check("R9 still driving", drv_on, 1'b1);
    ticks(1);
    check("R9 trip after full count", dom_to, 1'b1);
    set_txd(1'b1);
  endtask

  task automatic t_floating_reset;
    do_reset(1'b0);
    #1;
    check("R10 dominant from reset", drv_on, 1'b1);
    ticks(TO - 1);
    check("R10 not yet", dom_to, 1'b0);
    ticks(1);
    check("R10 trip from reset", dom_to, 1'b1);
    check("R10 drv off", drv_on, 1'b0);
    set_txd(1'b1);
  endtask

  task automatic t_gated_counting;
    @(negedge clk); tx_en = 1'b0; fault = 1'b1;
    set_txd(1'b0);
    ticks(TO);
    check("R11 counted while gated", dom_to, 1'b1);
    @(negedge clk); tx_en = 1'b1; fault = 1'b0;
    @(negedge clk);
    check("R11 stays off on enable", drv_on, 1'b0);
    set_txd(1'b1);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    t_reset_state();
    t_latency();
    t_enable_fault();
    t_boundary();
    t_restart_pulse();
    t_floating_reset();
    t_gated_counting();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule